// File: doc/BRIEF.md
# Dictionary Pattern Word Compressor

This block compresses a cache line as a stream of 32-bit words, taking one word per clock. Each word is compared with two fixed zero patterns and with a small dictionary of earlier words from the same line. Dictionary comparisons are made on the whole word, on its upper three bytes and on its upper two bytes. For every word the block emits a short pattern code, a dictionary index when one applies, and only the bytes that matched nothing.

A raw pattern always applies, so every word gets a code. A running sum of emitted bits is kept for the line. As soon as that sum goes past a size limit, the rest of the line is dropped and the line is reported as uncompressible. When the last word of the line has been seen, the block reports the line's compressed size in bits and the power-of-two size class that holds it.

A cache fill path drives `line_start_i` once per line, either alone or together with the first word. It then streams the words with `word_valid_i` and marks the final one with `word_last_i`.

Top module: `dpc_word_compressor`

## Requirements
- R1: While reset is held and after it is released, `code_valid_o`, `line_done_o` and `uncompressible_o` are low until a word is accepted.
- R2: A word accepted with `word_valid_i` high produces its result one clock later. The code is right-aligned in `code_o` and its length is given in `code_len_o`. The codes are: zero word = 00 (len 2), raw = 01 (len 2), full dictionary match = 10 (len 2), upper 16 bits match = 1100 (len 4), upper 24 bits zero = 1101 (len 4), upper 24 bits match = 1110 (len 4).
- R3: Each pattern has a total cost in bits: zero 2, full 6, upper-24-zero 12, upper-24-match 16, upper-16-match 24, raw 34. The applicable pattern with the smallest cost is chosen, and this cost order is also the tie order. When several dictionary entries match, the lowest index is reported.
- R4: The new bytes are placed right-aligned in `payload_o`, with their bit count in `payload_bits_o`: 32 for raw, 16 for the upper-16 match, 8 for the two upper-24 patterns, and 0 otherwise. Every dictionary pattern also emits a 4-bit index, flagged by `idx_used_o`.
- R5: The dictionary holds 16 entries and is filled in arrival order, starting at index 0. Words coded raw, upper-16 match or upper-24 match are inserted. Words coded zero, upper-24 zero or full match are not.
- R6: `line_start_i` empties the dictionary and clears the running size. A word accepted in the same cycle is coded as the first word of the new line.
- R7: When a word would raise the running size above `SIZE_LIMIT` (512), that word and all later words of the line produce no code (`code_valid_o` low). At line end, `uncompressible_o` is high and `line_bits_o` reports the raw line size of 512 bits.
- R8: `line_done_o` pulses in the same cycle as the last word's result. `line_bits_o` then equals the sum of code, index and payload bits over the line.
- R9: On `line_done_o`, `size_class_o` is the smallest power of two, at least 2, that is not below `line_bits_o` (for example, 100 bits gives 128).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start_i | input | 1 | Begin a new line |
| word_valid_i | input | 1 | Input word present |
| word_i | input | 32 | Input word |
| word_last_i | input | 1 | Word is the final one of the line |
| code_valid_o | output | 1 | Code fields hold a result |
| code_o | output | 4 | Pattern code, right-aligned |
| code_len_o | output | 3 | Code length in bits |
| dict_idx_o | output | 4 | Dictionary index |
| idx_used_o | output | 1 | Index is part of the output |
| payload_o | output | 32 | Unmatched bytes, right-aligned |
| payload_bits_o | output | 6 | Payload length in bits |
| line_done_o | output | 1 | Line result valid |
| line_bits_o | output | 10 | Compressed line size in bits |
| size_class_o | output | 11 | Power-of-two size class |
| uncompressible_o | output | 1 | Line exceeded the size limit |

## Verification
The bench targets words that match several patterns at once, which would expose a wrong priority through a longer code. It uses lines where several dictionary entries share their upper bytes, where a wrong index choice shows up as a wrong `dict_idx_o`. A line of sixteen raw words crosses the limit only on its last word; an off-by-one comparison would either code that word or miss the uncompressible flag. Some lines start in the same cycle as their first word, and a design that cleared the dictionary late would report a stale full match there. Random lines built from a small pool of values check insertion order through the indices that later matches report.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

   typedef enum logic [2:0] {
      PAT_ZERO,
      PAT_FULL,
      PAT_LOW1,
      PAT_HI3,
      PAT_HI2,
      PAT_RAW
   } pat_e;

   function automatic logic [3:0] pat_code(pat_e p);
      case (p)
         PAT_ZERO: return 4'h0;
         PAT_RAW:  return 4'h1;
         PAT_FULL: return 4'h2;
         PAT_HI2:  return 4'hC;
         PAT_LOW1: return 4'hD;
         default:  return 4'hE;
      endcase
   endfunction

   function automatic logic [2:0] pat_code_len(pat_e p);
      return (p == PAT_ZERO || p == PAT_RAW || p == PAT_FULL) ? 3'd2 : 3'd4;
   endfunction

   function automatic logic pat_uses_dict(pat_e p);
      return (p == PAT_FULL || p == PAT_HI3 || p == PAT_HI2);
   endfunction

   function automatic logic pat_inserts(pat_e p);
      return (p == PAT_RAW || p == PAT_HI3 || p == PAT_HI2);
   endfunction

   function automatic int pat_new_bytes(pat_e p);
      case (p)
         PAT_RAW:           return 4;
         PAT_HI2:           return 2;
         PAT_HI3, PAT_LOW1: return 1;
         default:           return 0;
      endcase
   endfunction

endpackage

// File: rtl/dpc_dict.sv
module dpc_dict #(
   parameter int DEPTH = 16,
   parameter int W     = 32,
   parameter int IW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          push_i,
   input  logic [W-1:0]  push_word_i,
   input  logic [W-1:0]  probe_i,
   output logic          hit_full_o,
   output logic [IW-1:0] idx_full_o,
   output logic          hit_hi3_o,
   output logic [IW-1:0] idx_hi3_o,
   output logic          hit_hi2_o,
   output logic [IW-1:0] idx_hi2_o
);

   logic [W-1:0]     ent_q [DEPTH];
   logic [DEPTH-1:0] vld_q;
   logic [DEPTH-1:0] live;
   logic [IW-1:0]    wp_q;
   logic [IW-1:0]    wbase;
   logic [DEPTH-1:0] m_full, m_hi3, m_hi2;

   assign live  = clear_i ? '0 : vld_q;
   assign wbase = clear_i ? '0 : wp_q;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign m_full[g] = live[g] && (ent_q[g] == probe_i);
      assign m_hi3[g]  = live[g] && (ent_q[g][W-1:8] == probe_i[W-1:8]);
      assign m_hi2[g]  = live[g] && (ent_q[g][W-1:16] == probe_i[W-1:16]);
   end

   // lowest matching index wins
   always_comb begin
      idx_full_o = '0;
      idx_hi3_o  = '0;
      idx_hi2_o  = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (m_full[i]) idx_full_o = IW'(i);
         if (m_hi3[i])  idx_hi3_o  = IW'(i);
         if (m_hi2[i])  idx_hi2_o  = IW'(i);
      end
   end

   assign hit_full_o = |m_full;
   assign hit_hi3_o  = |m_hi3;
   assign hit_hi2_o  = |m_hi2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         wp_q  <= '0;
      end else begin
         if (clear_i) vld_q <= '0;
         if (push_i) begin
            vld_q[wbase] <= 1'b1;
            wp_q         <= wbase + IW'(1);
         end else if (clear_i) begin
            wp_q <= '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (push_i) ent_q[wbase] <= push_word_i;
   end

endmodule

// File: rtl/dpc_pick.sv
module dpc_pick
   import dpc_pkg::*;
#(
   parameter int W    = 32,
   parameter int IW   = 4,
   parameter int PB_W = 6,
   parameter int WB_W = 6
) (
   input  logic [W-1:0]    word_i,
   input  logic            hit_full_i,
   input  logic [IW-1:0]   idx_full_i,
   input  logic            hit_hi3_i,
   input  logic [IW-1:0]   idx_hi3_i,
   input  logic            hit_hi2_i,
   input  logic [IW-1:0]   idx_hi2_i,
   output logic [3:0]      code_o,
   output logic [2:0]      code_len_o,
   output logic [IW-1:0]   idx_o,
   output logic            idx_used_o,
   output logic [W-1:0]    payload_o,
   output logic [PB_W-1:0] pay_bits_o,
   output logic [WB_W-1:0] word_bits_o,
   output logic            push_o
);

   pat_e pat;

   // ordered by cost: 2, 6, 12, 16, 24, 34 bits
   always_comb begin
      if (word_i == '0)               pat = PAT_ZERO;
      else if (hit_full_i)            pat = PAT_FULL;
      else if (word_i[W-1:8] == '0)   pat = PAT_LOW1;
      else if (hit_hi3_i)             pat = PAT_HI3;
      else if (hit_hi2_i)             pat = PAT_HI2;
      else                            pat = PAT_RAW;
   end

   always_comb begin
      case (pat)
         PAT_FULL: idx_o = idx_full_i;
         PAT_HI3:  idx_o = idx_hi3_i;
         PAT_HI2:  idx_o = idx_hi2_i;
         default:  idx_o = '0;
      endcase
      case (pat_new_bytes(pat))
         4:       payload_o = word_i;
         2:       payload_o = {{(W-16){1'b0}}, word_i[15:0]};
         1:       payload_o = {{(W-8){1'b0}}, word_i[7:0]};
         default: payload_o = '0;
      endcase
   end

   assign code_o      = pat_code(pat);
   assign code_len_o  = pat_code_len(pat);
   assign idx_used_o  = pat_uses_dict(pat);
   assign push_o      = pat_inserts(pat);
   assign pay_bits_o  = PB_W'(8 * pat_new_bytes(pat));
   assign word_bits_o = WB_W'(code_len_o) + (idx_used_o ? WB_W'(IW) : '0) + WB_W'(pay_bits_o);

endmodule

// File: rtl/dpc_word_compressor.sv
module dpc_word_compressor #(
   parameter int DICT_DEPTH = 16,
   parameter int LINE_WORDS = 16,
   parameter int SIZE_LIMIT = 512,
   localparam int WORD_W   = 32,
   localparam int IDX_W    = $clog2(DICT_DEPTH),
   localparam int RAW_BITS = LINE_WORDS * WORD_W,
   localparam int MAXV     = (SIZE_LIMIT > RAW_BITS) ? SIZE_LIMIT : RAW_BITS,
   localparam int SIZE_W   = $clog2(MAXV + 1),
   localparam int CLASS_W  = SIZE_W + 1,
   localparam int PB_W     = $clog2(WORD_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_start_i,
   input  logic               word_valid_i,
   input  logic [WORD_W-1:0]  word_i,
   input  logic               word_last_i,
   output logic               code_valid_o,
   output logic [3:0]         code_o,
   output logic [2:0]         code_len_o,
   output logic [IDX_W-1:0]   dict_idx_o,
   output logic               idx_used_o,
   output logic [WORD_W-1:0]  payload_o,
   output logic [PB_W-1:0]    payload_bits_o,
   output logic               line_done_o,
   output logic [SIZE_W-1:0]  line_bits_o,
   output logic [CLASS_W-1:0] size_class_o,
   output logic               uncompressible_o
);

   localparam int WB_W = $clog2(4 + IDX_W + WORD_W + 1);

   if (DICT_DEPTH < 2 || (DICT_DEPTH & (DICT_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DICT_DEPTH must be a power of two of at least 2");
   end
   if (SIZE_LIMIT < 2) begin : g_bad_limit
      $error("SIZE_LIMIT must be at least 2");
   end
   if (LINE_WORDS < 1) begin : g_bad_words
      $error("LINE_WORDS must be at least 1");
   end

   logic               hit_f, hit_3, hit_2;
   logic [IDX_W-1:0]   ix_f, ix_3, ix_2;
   logic [3:0]         p_code;
   logic [2:0]         p_len;
   logic [IDX_W-1:0]   p_idx;
   logic               p_iu, p_push;
   logic [WORD_W-1:0]  p_pay;
   logic [PB_W-1:0]    p_pb;
   logic [WB_W-1:0]    p_wb;

   dpc_dict #(.DEPTH(DICT_DEPTH), .W(WORD_W), .IW(IDX_W)) dict_i (
      .clk(clk), .rst_n(rst_n),
      .clear_i(line_start_i),
      .push_i(word_valid_i && p_push),
      .push_word_i(word_i),
      .probe_i(word_i),
      .hit_full_o(hit_f), .idx_full_o(ix_f),
      .hit_hi3_o(hit_3),  .idx_hi3_o(ix_3),
      .hit_hi2_o(hit_2),  .idx_hi2_o(ix_2)
   );

   dpc_pick #(.W(WORD_W), .IW(IDX_W), .PB_W(PB_W), .WB_W(WB_W)) pick_i (
      .word_i(word_i),
      .hit_full_i(hit_f), .idx_full_i(ix_f),
      .hit_hi3_i(hit_3),  .idx_hi3_i(ix_3),
      .hit_hi2_i(hit_2),  .idx_hi2_i(ix_2),
      .code_o(p_code), .code_len_o(p_len), .idx_o(p_idx), .idx_used_o(p_iu),
      .payload_o(p_pay), .pay_bits_o(p_pb), .word_bits_o(p_wb), .push_o(p_push)
   );

   logic [SIZE_W-1:0] total_q, base_total;
   logic              ab_q, base_ab, over;
   logic [SIZE_W:0]   sum;

   assign base_total = line_start_i ? '0 : total_q;
   assign base_ab    = line_start_i ? 1'b0 : ab_q;
   assign sum        = {1'b0, base_total} + (SIZE_W + 1)'(p_wb);
   assign over       = base_ab || (sum > (SIZE_W + 1)'(SIZE_LIMIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         total_q          <= '0;
         ab_q             <= 1'b0;
         code_valid_o     <= 1'b0;
         code_o           <= '0;
         code_len_o       <= '0;
         dict_idx_o       <= '0;
         idx_used_o       <= 1'b0;
         payload_o        <= '0;
         payload_bits_o   <= '0;
         line_done_o      <= 1'b0;
         line_bits_o      <= '0;
         uncompressible_o <= 1'b0;
      end else begin
         code_valid_o <= word_valid_i && !over;
         line_done_o  <= word_valid_i && word_last_i;
         if (word_valid_i) begin
            code_o         <= p_code;
            code_len_o     <= p_len;
            dict_idx_o     <= p_idx;
            idx_used_o     <= p_iu;
            payload_o      <= p_pay;
            payload_bits_o <= p_pb;
            total_q        <= over ? base_total : sum[SIZE_W-1:0];
            ab_q           <= over;
            if (word_last_i) begin
               line_bits_o      <= over ? SIZE_W'(RAW_BITS) : sum[SIZE_W-1:0];
               uncompressible_o <= over;
            end
         end else if (line_start_i) begin
            total_q <= '0;
            ab_q    <= 1'b0;
         end
      end
   end

   // smallest power of two (>= 2) covering the reported size
   always_comb begin
      size_class_o = '0;
      for (int k = CLASS_W - 1; k >= 1; k--) begin
         if ((CLASS_W'(1) << k) >= CLASS_W'(line_bits_o)) size_class_o = CLASS_W'(1) << k;
      end
   end

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
   parameter int DICT_DEPTH = 16,
   parameter int LINE_WORDS = 16,
   parameter int SIZE_LIMIT = 512,
   localparam int RAW_BITS = LINE_WORDS * 32,
   localparam int MAXV     = (SIZE_LIMIT > RAW_BITS) ? SIZE_LIMIT : RAW_BITS,
   localparam int SIZE_W   = $clog2(MAXV + 1),
   localparam int CLASS_W  = SIZE_W + 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               word_valid_i,
   input logic               word_last_i,
   input logic               code_valid_o,
   input logic [3:0]         code_o,
   input logic               idx_used_o,
   input logic [31:0]        payload_o,
   input logic [5:0]         payload_bits_o,
   input logic               line_done_o,
   input logic [SIZE_W-1:0]  line_bits_o,
   input logic [CLASS_W-1:0] size_class_o,
   input logic               uncompressible_o
);

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      code_valid_o |-> $past(word_valid_i));

   assert_dict_codes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (code_valid_o && idx_used_o) |-> (code_o == 4'h2 || code_o == 4'hC || code_o == 4'hE));

   assert_payload_R4: assert property (@(posedge clk) disable iff (!rst_n)
      code_valid_o |-> ((payload_bits_o == 6'd0 || payload_bits_o == 6'd8 ||
                         payload_bits_o == 6'd16 || payload_bits_o == 6'd32) &&
                        ((64'(payload_o) >> payload_bits_o) == 64'd0)));

   assert_under_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (line_done_o && !uncompressible_o) |-> (int'(line_bits_o) <= SIZE_LIMIT));

   assert_raw_size_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (line_done_o && uncompressible_o) |-> (int'(line_bits_o) == RAW_BITS));

   assert_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      line_done_o |-> $past(word_valid_i && word_last_i));

   assert_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
      line_done_o |-> ($countones(size_class_o) == 1 &&
                       int'(size_class_o) >= int'(line_bits_o) &&
                       (int'(size_class_o) == 2 || int'(size_class_o) < 2 * int'(line_bits_o))));

endmodule

bind dpc_word_compressor dpc_checker #(
   .DICT_DEPTH(DICT_DEPTH), .LINE_WORDS(LINE_WORDS), .SIZE_LIMIT(SIZE_LIMIT)
) chk_i (
   .clk(clk), .rst_n(rst_n),
   .word_valid_i(word_valid_i), .word_last_i(word_last_i),
   .code_valid_o(code_valid_o), .code_o(code_o), .idx_used_o(idx_used_o),
   .payload_o(payload_o), .payload_bits_o(payload_bits_o),
   .line_done_o(line_done_o), .line_bits_o(line_bits_o),
   .size_class_o(size_class_o), .uncompressible_o(uncompressible_o)
);

// File: tb/dpc_word_compressor_tb_top.sv
module dpc_word_compressor_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_start_i = 1'b0;
   logic        word_valid_i = 1'b0;
   logic [31:0] word_i = '0;
   logic        word_last_i = 1'b0;
   logic        code_valid_o;
   logic [3:0]  code_o;
   logic [2:0]  code_len_o;
   logic [3:0]  dict_idx_o;
   logic        idx_used_o;
   logic [31:0] payload_o;
   logic [5:0]  payload_bits_o;
   logic        line_done_o;
   logic [9:0]  line_bits_o;
   logic [10:0] size_class_o;
   logic        uncompressible_o;

   always #10 clk = ~clk;

   dpc_word_compressor dut_i (
      .clk(clk), .rst_n(rst_n), .line_start_i(line_start_i),
      .word_valid_i(word_valid_i), .word_i(word_i), .word_last_i(word_last_i),
      .code_valid_o(code_valid_o), .code_o(code_o), .code_len_o(code_len_o),
      .dict_idx_o(dict_idx_o), .idx_used_o(idx_used_o), .payload_o(payload_o),
      .payload_bits_o(payload_bits_o), .line_done_o(line_done_o),
      .line_bits_o(line_bits_o), .size_class_o(size_class_o),
      .uncompressible_o(uncompressible_o)
   );

   int total_checks = 0;
   int bad_checks = 0;

   // reference model state
   logic [31:0] dq[$];
   int  run_total = 0;
   bit  run_ab = 0;
   bit  e_cv = 0, e_done = 0, e_unc = 0, e_iu = 0;
   int  e_code = 0, e_len = 0, e_idx = 0, e_pb = 0, e_size = 0, e_class = 0;
   logic [31:0] e_pay = '0;

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      total_checks++;
      if (act !== exp) begin
         bad_checks++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic check_outputs();
      chk("R2/R7", "code_valid", 64'(code_valid_o), 64'(e_cv));
      if (e_cv) begin
         chk("R3", "code", 64'(code_o), 64'(e_code));
         chk("R2", "code_len", 64'(code_len_o), 64'(e_len));
         chk("R4", "idx_used", 64'(idx_used_o), 64'(e_iu));
         if (e_iu) chk("R5", "dict_idx", 64'(dict_idx_o), 64'(e_idx));
         chk("R4", "payload", 64'(payload_o), 64'(e_pay));
         chk("R4", "payload_bits", 64'(payload_bits_o), 64'(e_pb));
      end
      chk("R8", "line_done", 64'(line_done_o), 64'(e_done));
      if (e_done) begin
         chk("R8", "line_bits", 64'(line_bits_o), 64'(e_size));
         chk("R7", "uncompressible", 64'(uncompressible_o), 64'(e_unc));
         chk("R9", "size_class", 64'(size_class_o), 64'(e_class));
      end
   endtask

   task automatic model_word(bit ls, bit v, logic [31:0] w, bit last);
      int fi, h3, h2, sz, c;
      if (ls) begin
         dq.delete();
         run_total = 0;
         run_ab = 0;
      end
      e_cv = 0;
      e_done = 0;
      if (!v) return;
      fi = -1; h3 = -1; h2 = -1;
      foreach (dq[i]) begin
         if (fi < 0 && dq[i] == w) fi = i;
         if (h3 < 0 && dq[i][31:8] == w[31:8]) h3 = i;
         if (h2 < 0 && dq[i][31:16] == w[31:16]) h2 = i;
      end
      // candidates tried in tie order; strictly smaller cost replaces
      sz = 1000;
      if (w == 0 && 2 < sz) begin sz = 2; e_code = 0; e_len = 2; e_iu = 0; e_pb = 0; e_pay = 0; end
      if (fi >= 0 && 6 < sz) begin sz = 6; e_code = 2; e_len = 2; e_iu = 1; e_idx = fi; e_pb = 0; e_pay = 0; end
      if (w[31:8] == 0 && 12 < sz) begin sz = 12; e_code = 13; e_len = 4; e_iu = 0; e_pb = 8; e_pay = {24'd0, w[7:0]}; end
      if (h3 >= 0 && 16 < sz) begin sz = 16; e_code = 14; e_len = 4; e_iu = 1; e_idx = h3; e_pb = 8; e_pay = {24'd0, w[7:0]}; end
      if (h2 >= 0 && 24 < sz) begin sz = 24; e_code = 12; e_len = 4; e_iu = 1; e_idx = h2; e_pb = 16; e_pay = {16'd0, w[15:0]}; end
      if (34 < sz) begin sz = 34; e_code = 1; e_len = 2; e_iu = 0; e_pb = 32; e_pay = w; end
      if (e_code == 1 || e_code == 12 || e_code == 14) dq.push_back(w);
      if (run_ab || run_total + sz > 512) run_ab = 1;
      else begin
         run_total += sz;
         e_cv = 1;
      end
      if (last) begin
         e_done = 1;
         e_unc = run_ab;
         e_size = run_ab ? 512 : run_total;
         c = 2;
         while (c < e_size) c = c * 2;
         e_class = c;
      end
   endtask

   task automatic step(bit ls, bit v, logic [31:0] w, bit last);
      @(negedge clk);
      check_outputs();
      line_start_i = ls;
      word_valid_i = v;
      word_i       = w;
      word_last_i  = last;
      model_word(ls, v, w, last);
   endtask

   task automatic send_line(logic [31:0] words[$], bit together, bit gaps);
      if (!together) step(1, 0, 0, 0);
      foreach (words[i]) begin
         if (gaps && ($urandom % 4 == 0)) step(0, 0, 32'hDEAD_0000, 0);
         step(together && i == 0, 1, words[i], i == words.size() - 1);
      end
   endtask

   function automatic logic [31:0] rnd_word();
      logic [31:0] pool[4] = '{32'h1234_5678, 32'hCAFE_BABE, 32'h0BAD_F00D, 32'h7777_0001};
      logic [31:0] p;
      p = pool[$urandom % 4];
      case ($urandom % 6)
         0: return 32'd0;
         1: return {24'd0, 8'($urandom)};
         2: return p;
         3: return {p[31:8], 8'($urandom)};
         4: return {p[31:16], 16'($urandom)};
         default: return $urandom;
      endcase
   endfunction

   initial begin
      logic [31:0] ln[$];
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", "code_valid in reset", 64'(code_valid_o), 64'd0);
      chk("R1", "line_done in reset", 64'(line_done_o), 64'd0);
      chk("R1", "uncompressible in reset", 64'(uncompressible_o), 64'd0);
      rst_n = 1'b1;
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);

      // R3 R5: each pattern, lowest-index choice, insertion order
      ln = '{32'h0, 32'h1234_5678, 32'h1234_5678, 32'h0000_00AB, 32'h1234_56FF,
             32'h1234_ABCD, 32'h1234_ABCD, 32'hCAFE_BABE, 32'h1234_ABCD,
             32'h1234_0000, 32'hCAFE_BA00, 32'h1234_5678};
      send_line(ln, 0, 0);
      step(0, 0, 0, 0);

      // R6: start coincides with first word; stale entries must be gone
      ln = '{32'h1234_5678, 32'h1234_5678, 32'hCAFE_BABE};
      send_line(ln, 1, 0);

      // R7: sixteen raw words cross the limit on the last one
      ln.delete();
      for (int i = 0; i < 16; i++) ln.push_back({16'(16'h0100 + i), 16'h5555});
      send_line(ln, 0, 0);
      step(0, 0, 0, 0);

      // R9: a small line
      ln = '{32'h0000_0011, 32'h0};
      send_line(ln, 1, 0);

      // random lines, sometimes with idle gaps
      for (int n = 0; n < 60; n++) begin
         ln.delete();
         for (int i = 0; i < 16; i++) ln.push_back(rnd_word());
         send_line(ln, n[0], n[1]);
      end
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);

      $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total_checks++;
      bad_checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
      $finish;
   end

endmodule